// File: doc/BRIEF.md
# Dual-Clock FIFO With Selectable Timing Mode

This block is a first-in first-out buffer between two clock domains. A producer writes 36-bit words on its own clock with a write enable, and a consumer reads them on an unrelated clock with a read enable. Both sides can run at the same time. Each side keeps a binary pointer with one extra wrap bit. The pointer is passed to the other side as a Gray-coded value through a two-flop synchronizer. Storage is a register array with `1 << AW` entries, 1024 by default.

A mode input selects one of two read timings. In standard mode a word appears on the read data output only after a read request, and the two flag outputs mean "empty" and "full". In fall-through mode the oldest word is moved into the output register without any request, and the flags mean "output ready" and "input ready". The mode is captured on the first edge of each clock after the master reset is released. The master reset clears the mode, the pointers and the flags. The partial reset clears only the pointers and the flags, so the buffer is emptied but the captured mode is kept. A retransmit pulse sends the read pointer back to the first word written since the last reset. In standard mode the very next read returns that word.

Top module: `dcf_fifo`

## Requirements
- R1: After a master reset in standard mode, `rflag_o`=1 (empty), `wflag_o`=0 (not full) and `half_o`=0. After a master reset in fall-through mode, `rflag_o`=0 (no word ready) and `wflag_o`=1 (input ready).
- R2: In standard mode, words come out in the order they were written. `rdata_o` changes only on a read clock edge where `ren_i`=1 and the buffer is not empty, and it then holds the oldest unread word.
- R3: In standard mode, `rflag_o` returns to 1 once every written word has been read, after the synchronizer delay.
- R4: In standard mode, `wflag_o`=1 once `1<<AW` words are stored and not read. A write while full is dropped and leaves the write pointer unchanged, so reading back afterwards gives exactly the stored words.
- R5: A read request while empty in standard mode is ignored. `rdata_o` keeps its value and the read pointer does not move, so the next word written is the next word read.
- R6: `half_o`=1 exactly when more than `(1<<AW)/2` words are held, as counted by the write side.
- R7: In fall-through mode, the first word written reaches `rdata_o` and `rflag_o` rises with no read request. A read then advances to the next word.
- R8: In fall-through mode `wflag_o` is the inverse of full. Because the output register holds one word, the buffer takes `(1<<AW)+1` words before `wflag_o` drops to 0. Further writes are dropped.
- R9: `fwft_i` (1 = fall-through, 0 = standard) is captured only on the first clock edge after `rst_ni` is released. Later changes have no effect.
- R10: A partial reset (`prst_ni`=0) empties the buffer and keeps the captured mode.
- R11: In standard mode, a one-cycle `rt_i` pulse moves the read point back to the first word written since the last reset, and the next read returns it. This is valid while writes are idle and fewer than `1<<AW` words have been written since that reset.
- R12: Writes and reads that run concurrently on unrelated clocks deliver every word intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| prst_ni | input | 1 | Partial reset, active low, asynchronous, keeps mode |
| fwft_i | input | 1 | Mode select, captured after master reset (1 = fall-through) |
| wen_i | input | 1 | Write enable, write clock domain |
| wdata_i | input | DW | Write data |
| ren_i | input | 1 | Read enable, read clock domain |
| rt_i | input | 1 | Retransmit pulse, read clock domain |
| rdata_o | output | DW | Read data register |
| wflag_o | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| rflag_o | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| half_o | output | 1 | More than half of the entries occupied |

## Verification
Data is streamed through the buffer in several ways:
- A table of bit patterns (all zeros, all ones, alternating, walking bits) is written and read back. Any swapped bit or reordered entry shows up.
- Filling past capacity in both modes, with a marker word appended, shows whether a write while full is dropped.
- The half-full threshold is checked one word below and one word above the limit.
- A concurrent stream on the two unrelated clocks tests the Gray handoff.
- Retransmit, a late change of `fwft_i`, and a partial reset each run on a partly filled buffer. This separates data that is rewound or cleared from the mode, which must survive.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } dcf_mode_e;
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/dcf_mode_latch.sv
module dcf_mode_latch
  import dcf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fwft_i,
  output dcf_mode_e mode_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_o  <= MODE_STD;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      mode_o  <= dcf_mode_e'(fwft_i);
    end
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  dcf_mode_e     mode_i,
  input  logic          wen_i,
  input  logic [AW:0]   rgray_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          wflag_o,
  output logic          half_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wptr_q, wnext, rbin, fill;
  logic          full;

  dcf_gray_sync #(.W(PW)) u_rsync (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .gray_i(rgray_i),
    .bin_o (rbin)
  );

  assign fill    = wptr_q - rbin;
  assign full    = (fill == PW'(DEPTH));
  assign we_o    = wen_i && !full;
  assign wnext   = wptr_q + PW'(we_o);
  assign waddr_o = wptr_q[AW-1:0];
  assign half_o  = (fill > PW'(DEPTH / 2));
  assign wflag_o = (mode_i == MODE_FWFT) ? !full : full;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_o <= '0;
    end else begin
      wptr_q  <= wnext;
      wgray_o <= wnext ^ (wnext >> 1);
    end
  end

  a_r4_no_write_when_full: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wen_i && full) |=> $stable(wptr_q));
  a_r4_fill_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    fill <= PW'(DEPTH));
  a_r6_full_implies_half: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full |-> half_o);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  dcf_mode_e     mode_i,
  input  logic          ren_i,
  input  logic          rt_i,
  input  logic [AW:0]   wgray_i,
  input  logic [DW-1:0] ram_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          rflag_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr_q, rnext, wbin;
  logic          empty_ram, pop, valid_q;

  dcf_gray_sync #(.W(PW)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wgray_i),
    .bin_o (wbin)
  );

  assign empty_ram = (rptr_q == wbin);
  // fall-through prefetches whenever the output register is free
  assign pop     = !rt_i && !empty_ram &&
                   ((mode_i == MODE_FWFT) ? (!valid_q || ren_i) : ren_i);
  assign rnext   = rt_i ? '0 : rptr_q + PW'(pop);
  assign raddr_o = rptr_q[AW-1:0];
  assign rflag_o = (mode_i == MODE_FWFT) ? valid_q : empty_ram;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_o <= '0;
      rdata_o <= '0;
      valid_q <= 1'b0;
    end else begin
      rptr_q  <= rnext;
      rgray_o <= rnext ^ (rnext >> 1);
      if (rt_i) begin
        valid_q <= 1'b0;
      end else if (pop) begin
        rdata_o <= ram_i;
        valid_q <= 1'b1;
      end else if (ren_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  a_r5_no_read_when_empty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_i == MODE_STD && ren_i && empty_ram && !rt_i) |=> $stable(rptr_q));
  a_r2_data_holds_without_read: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_i == MODE_STD && !(ren_i && !rflag_o)) |=> $stable(rdata_o));
  a_r7_ready_needs_data: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_i == MODE_FWFT && $rose(valid_q)) |-> $past(!empty_ram));
  a_r11_rewind_clears_gray: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rt_i |=> (rgray_o == '0));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  input  logic          rt_i,
  output logic [DW-1:0] rdata_o,
  output logic          wflag_o,
  output logic          rflag_o,
  output logic          half_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic          data_rst_n, we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray;
  dcf_mode_e     wmode, rmode;

  // partial reset clears pointers only; mode latches see master reset alone
  assign data_rst_n = rst_ni & prst_ni;

  dcf_mode_latch u_wmode (.clk_i(wclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i), .mode_o(wmode));
  dcf_mode_latch u_rmode (.clk_i(rclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i), .mode_o(rmode));

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .wclk_i (wclk_i),
    .rst_ni (data_rst_n),
    .mode_i (wmode),
    .wen_i  (wen_i),
    .rgray_i(rgray),
    .we_o   (we),
    .waddr_o(waddr),
    .wgray_o(wgray),
    .wflag_o(wflag_o),
    .half_o (half_o)
  );

  dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .rclk_i (rclk_i),
    .rst_ni (data_rst_n),
    .mode_i (rmode),
    .ren_i  (ren_i),
    .rt_i   (rt_i),
    .wgray_i(wgray),
    .ram_i  (mem_q[raddr]),
    .raddr_o(raddr),
    .rgray_o(rgray),
    .rdata_o(rdata_o),
    .rflag_o(rflag_o)
  );

  always_ff @(posedge wclk_i) begin
    if (we) mem_q[waddr] <= wdata_i;
  end
endmodule

// File: tb/tb_dcf_fifo.sv
`timescale 1ns/1ps
module tb_dcf_fifo;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NV = 8;
  localparam logic [DW-1:0] VEC [NV] = '{
    36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'hA_AAAA_AAAA, 36'h5_5555_5555,
    36'h0_0000_0001, 36'h8_0000_0000, 36'h1_2345_6789, 36'hE_DCBA_9876
  };

  logic wclk = 0, rclk = 0;
  logic rst_n = 0, prst_n = 1, fwft = 0, wen = 0, ren = 0, rt = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic wflag, rflag, half;
  int vecs = 0, errs = 0;

  always #2 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcf_fifo #(.AW(AW), .DW(DW)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prst_ni(prst_n), .fwft_i(fwft),
    .wen_i(wen), .wdata_i(wdata), .ren_i(ren), .rt_i(rt),
    .rdata_o(rdata), .wflag_o(wflag), .rflag_o(rflag), .half_o(half)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic mode);
    rst_n = 0; prst_n = 1; fwft = mode; wen = 0; ren = 0; rt = 0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    repeat (4) @(negedge rclk);
  endtask

  task automatic wr(logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1; wdata = d;
  endtask

  task automatic wr_end();
    @(negedge wclk);
    wen = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
  endtask

  task automatic rd_std(logic [DW-1:0] exp, string req);
    int n = 0;
    @(negedge rclk);
    while (rflag && n < 100) begin @(negedge rclk); n++; end
    if (rflag) chk({req, " timeout"}, '1, '0);
    ren = 1;
    @(negedge rclk);
    ren = 0;
    chk(req, rdata, exp);
  endtask

  task automatic rd_ft(logic [DW-1:0] exp, string req);
    int n = 0;
    @(negedge rclk);
    while (!rflag && n < 100) begin @(negedge rclk); n++; end
    chk({req, " ready"}, DW'(rflag), DW'(1));
    chk(req, rdata, exp);
    ren = 1;
    @(negedge rclk);
    ren = 0;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    errs++;
    $display("FAIL watchdog actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // R1 standard reset state
    do_reset(0);
    chk("R1 empty", DW'(rflag), DW'(1));
    chk("R1 full", DW'(wflag), DW'(0));
    chk("R1 half", DW'(half), DW'(0));

    // R2 table walk
    for (int i = 0; i < NV; i++) wr(VEC[i]);
    wr_end();
    for (int i = 0; i < NV; i++) rd_std(VEC[i], "R2 order");
    settle();
    chk("R3 empty after drain", DW'(rflag), DW'(1));

    // R5 read while empty
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
    chk("R5 data held", rdata, VEC[NV-1]);
    chk("R5 still empty", DW'(rflag), DW'(1));
    wr(36'h0_0000_00A5); wr_end();
    rd_std(36'h0_0000_00A5, "R5 pointer unmoved");

    // R4 overflow
    do_reset(0);
    for (int i = 0; i < DEPTH; i++) wr(DW'(i + 16));
    wr(36'hB_ADBA_DBAD);
    wr_end();
    settle();
    chk("R4 full", DW'(wflag), DW'(1));
    chk("R6 half at full", DW'(half), DW'(1));
    for (int i = 0; i < DEPTH; i++) rd_std(DW'(i + 16), "R4 stored");
    settle();
    chk("R4 extra dropped", DW'(rflag), DW'(1));
    chk("R4 full cleared", DW'(wflag), DW'(0));

    // R6 threshold
    do_reset(0);
    for (int i = 0; i < DEPTH / 2; i++) wr(DW'(i));
    wr_end(); settle();
    chk("R6 at half", DW'(half), DW'(0));
    wr(DW'(99)); wr_end(); settle();
    chk("R6 above half", DW'(half), DW'(1));

    // R11 retransmit
    do_reset(0);
    for (int i = 0; i < 4; i++) wr(36'h3_0000_0000 + DW'(i));
    wr_end();
    rd_std(36'h3_0000_0000, "R11 pre");
    rd_std(36'h3_0000_0001, "R11 pre");
    @(negedge rclk); rt = 1;
    @(negedge rclk); rt = 0;
    for (int i = 0; i < 4; i++) rd_std(36'h3_0000_0000 + DW'(i), "R11 replay");

    // R12 concurrent stream
    do_reset(0);
    fork
      begin
        for (int i = 0; i < 12; i++) wr(36'h7_7000_0000 + DW'(i * 3));
        wr_end();
      end
      begin
        for (int i = 0; i < 12; i++) rd_std(36'h7_7000_0000 + DW'(i * 3), "R12 stream");
      end
    join

    // R1 / R7 fall-through
    do_reset(1);
    chk("R1 ft not ready", DW'(rflag), DW'(0));
    chk("R1 ft input ready", DW'(wflag), DW'(1));
    for (int i = 0; i < 3; i++) wr(VEC[i + 2]);
    wr_end(); settle();
    chk("R7 ready without read", DW'(rflag), DW'(1));
    for (int i = 0; i < 3; i++) rd_ft(VEC[i + 2], "R7 fall-through");
    settle();
    chk("R7 drained", DW'(rflag), DW'(0));

    // R8 capacity in fall-through
    do_reset(1);
    for (int i = 0; i <= DEPTH; i++) wr(DW'(i + 256));
    wr(36'hB_ADBA_DBAD);
    wr_end(); settle();
    chk("R8 input not ready", DW'(wflag), DW'(0));
    for (int i = 0; i <= DEPTH; i++) rd_ft(DW'(i + 256), "R8 stored");
    settle();
    chk("R8 extra dropped", DW'(rflag), DW'(0));
    chk("R8 input ready", DW'(wflag), DW'(1));

    // R9 late mode change
    do_reset(1);
    fwft = 0;
    wr(36'h9_0000_0009); wr_end(); settle();
    chk("R9 mode kept", DW'(rflag), DW'(1));
    chk("R9 data", rdata, 36'h9_0000_0009);

    // R10 partial reset
    wr(36'h9_0000_000A); wr_end(); settle();
    @(negedge wclk); prst_n = 0;
    repeat (2) @(negedge wclk); prst_n = 1;
    settle();
    chk("R10 emptied", DW'(rflag), DW'(0));
    chk("R10 mode kept", DW'(wflag), DW'(1));
    wr(36'h1_0000_0010); wr_end();
    rd_ft(36'h1_0000_0010, "R10 after partial reset");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule